// File: doc/BRIEF.md
# Code/Data Memory Space Selector

This block sits on the external bus of a microcontroller whose external memory is split into a 64K code device and a 64K data device. It produces one select output, `space_code_o`, that works like a seventeenth address line: 1 selects the code memory and 0 selects the data memory. The controller raises an instruction-fetch status only when the program counter drives an external fetch, and immediate operands count as such fetches. Every other access, including vector-table and jump-table base reads, arrives with that status low.

The block corrects the status in two ways. First, a boot latch is set by reset and sends every access to code space, so the configuration byte is never read from data RAM. It clears on the first write strobe that the bus really drives. In 16-bit mode that means a write to an even address. Second, a fixed low address window always maps to code space, so vector fetches land in code memory. The window is either narrow (2000h to 207Fh) or wide (2000h to 3FFFh), chosen by the `wide_win` input.

The reset and both strobes are synchronized to the system clock. The select is registered on the first clock of a valid bus cycle in which a synchronized strobe is active. It is then held until the next such capture. Internal register cycles drive no strobes, so they change nothing.

Top module: `mem_space_sel`

## Requirements
- R1: While reset is asserted and just after it is released, `space_code_o` is 1 and the boot latch is set.
- R2: While the boot latch is set, a read with fetch status low at any address captures code space (1).
- R3: A write whose synchronized strobe falls during a valid cycle clears the latch when `bus16` is 1 and address bit 0 is 0. After that, a fetch-low read outside the window captures data space (0).
- R4: With `bus16` at 1, a write to an odd address (bit 0 = 1) leaves the latch set, and the next fetch-low read outside the window still gives 1.
- R5: With `bus16` at 0, a write to either address parity clears the latch.
- R6: With `wide_win` at 0, addresses 2000h to 207Fh capture 1 even with fetch status low. Addresses 1FFFh and 2080h follow the fetch status.
- R7: With `wide_win` at 1, addresses 2000h to 3FFFh capture 1 even with fetch status low. Address 4000h follows the fetch status.
- R8: With the latch clear and the address outside the window, the captured value equals the fetch status sampled in the capture cycle.
- R9: A valid cycle with both strobes inactive (an internal access) changes neither the output nor the latch.
- R10: `space_code_o` changes only on the clock after a capture. Between cycles it holds its value whatever the fetch status does.
- R11: A later reset sets the latch again after it has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronized inside |
| addr_i | input | 16 | Bus address, held through a cycle |
| fetch_i | input | 1 | Instruction-fetch status (1 = program-counter fetch) |
| rd_n | input | 1 | Active-low read strobe, asynchronous |
| wr_n | input | 1 | Active-low write strobe, asynchronous |
| cyc_vld_i | input | 1 | High for the whole of a bus cycle |
| bus16_i | input | 1 | 1 = 16-bit bus mode |
| wide_win_i | input | 1 | 1 = wide forced window, 0 = narrow |
| space_code_o | output | 1 | 1 = code memory, 0 = data memory |

## Verification
The bench uses the default window base and spans (2000h, 80h, 2000h) and two synchronizer stages. With those values the window edges 1FFFh, 2000h, 207Fh, 2080h, 3FFFh and 4000h are all reachable from one table. The two-stage delay lets a strobe held for six clocks reach capture well inside a cycle. Because `wide_win` is a port, both window widths are tested in the same run. The run also steps the latch through set, an odd write that keeps it set, an even write that clears it, an 8-bit-mode odd write that clears it, and a second reset.

// File: rtl/msel_pkg.sv
package msel_pkg;
  parameter int ADDR_W = 16;
  typedef logic [ADDR_W-1:0] addr_t;

  // Half-open window test [base, base+span), computed one bit wider to avoid wrap.
  function automatic logic in_window(addr_t a, addr_t base, logic [ADDR_W:0] span);
    logic [ADDR_W:0] ext_a;
    logic [ADDR_W:0] lim;
    ext_a = {1'b0, a};
    lim   = {1'b0, base} + span;
    return (ext_a >= {1'b0, base}) && (ext_a < lim);
  endfunction

  // A write strobe is seen on the bus only for even addresses in 16-bit mode.
  function automatic logic write_clears(addr_t a, logic wide_bus);
    return !(wide_bus && a[0]);
  endfunction

  // Space choice: boot override, window override, else fetch status.
  function automatic logic pick_space(logic boot, logic win, logic fetch);
    return boot | win | fetch;
  endfunction
endpackage

// File: rtl/msel_sync.sv
module msel_sync #(
  parameter int          WIDTH   = 1,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge arst_n)
        if (!arst_n) chain[s] <= RST_VAL;
        else         chain[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge arst_n)
        if (!arst_n) chain[s] <= RST_VAL;
        else         chain[s] <= chain[s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/msel_boot_latch.sv
module msel_boot_latch (
  input  logic clk,
  input  logic srst_n,
  input  logic clr_i,
  output logic boot_o
);
  always_ff @(posedge clk or negedge srst_n)
    if (!srst_n)    boot_o <= 1'b1;
    else if (clr_i) boot_o <= 1'b0;
endmodule

// File: rtl/msel_capture.sv
module msel_capture (
  input  logic clk,
  input  logic srst_n,
  input  logic cyc_vld_i,
  input  logic strobe_i,
  input  logic next_i,
  output logic capture_o,
  output logic space_o
);
  logic taken_q;

  assign capture_o = cyc_vld_i && strobe_i && !taken_q;

  always_ff @(posedge clk or negedge srst_n)
    if (!srst_n) begin
      taken_q <= 1'b0;
      space_o <= 1'b1;
    end else begin
      taken_q <= cyc_vld_i && (taken_q || strobe_i);
      if (capture_o) space_o <= next_i;
    end
endmodule

// File: rtl/mem_space_sel.sv
module mem_space_sel #(
  parameter int                     SYNC_STAGES = 2,
  parameter logic [15:0]            WIN_BASE    = 16'h2000,
  parameter logic [16:0]            NARROW_SPAN = 17'h00080,
  parameter logic [16:0]            WIDE_SPAN   = 17'h02000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] addr_i,
  input  logic        fetch_i,
  input  logic        rd_n,
  input  logic        wr_n,
  input  logic        cyc_vld_i,
  input  logic        bus16_i,
  input  logic        wide_win_i,
  output logic        space_code_o
);
  import msel_pkg::*;

  localparam int STB_W = 2;

  logic             srst_n;
  logic [STB_W-1:0] stb_s;
  logic             rd_s, wr_s, wr_s_q;
  logic             wr_fall, clr_evt, strobe_act, win_hit, boot_q, next_space, capture;
  logic [16:0]      span_sel;

  msel_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .arst_n(rst_n), .d_i(1'b1), .q_o(srst_n)
  );

  msel_sync #(.WIDTH(STB_W), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_stb_sync (
    .clk(clk), .arst_n(rst_n), .d_i({wr_n, rd_n}), .q_o(stb_s)
  );

  assign rd_s = stb_s[0];
  assign wr_s = stb_s[1];

  always_ff @(posedge clk or negedge srst_n)
    if (!srst_n) wr_s_q <= 1'b1;
    else         wr_s_q <= wr_s;

  assign wr_fall    = cyc_vld_i && wr_s_q && !wr_s;
  assign clr_evt    = wr_fall && write_clears(addr_i, bus16_i);
  assign strobe_act = !rd_s || !wr_s;
  assign span_sel   = wide_win_i ? WIDE_SPAN : NARROW_SPAN;
  assign win_hit    = in_window(addr_i, WIN_BASE, span_sel);

  msel_boot_latch u_boot (
    .clk(clk), .srst_n(srst_n), .clr_i(clr_evt), .boot_o(boot_q)
  );

  assign next_space = pick_space(boot_q, win_hit, fetch_i);

  msel_capture u_cap (
    .clk(clk), .srst_n(srst_n), .cyc_vld_i(cyc_vld_i), .strobe_i(strobe_act),
    .next_i(next_space), .capture_o(capture), .space_o(space_code_o)
  );
endmodule

// File: rtl/msel_checker.sv
module msel_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        srst_n,
  input logic        capture,
  input logic        boot_q,
  input logic        win_hit,
  input logic        wr_fall,
  input logic        clr_evt,
  input logic        bus16_i,
  input logic [15:0] addr_i,
  input logic        fetch_i,
  input logic        space_code_o
);
  p_reset_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !srst_n |=> boot_q);

  p_boot_code_r2: assert property (@(posedge clk) disable iff (!srst_n)
    capture && boot_q |=> space_code_o);

  p_clear_only_on_write_r3: assert property (@(posedge clk) disable iff (!srst_n)
    boot_q && !clr_evt |=> boot_q);

  p_odd_keep_r4: assert property (@(posedge clk) disable iff (!srst_n)
    wr_fall && bus16_i && addr_i[0] && boot_q |=> boot_q);

  p_window_code_r6: assert property (@(posedge clk) disable iff (!srst_n)
    capture && win_hit |=> space_code_o);

  p_follow_fetch_r8: assert property (@(posedge clk) disable iff (!srst_n)
    capture && !boot_q && !win_hit |=> space_code_o == $past(fetch_i));

  p_hold_r10: assert property (@(posedge clk) disable iff (!srst_n)
    !capture |=> $stable(space_code_o));
endmodule

bind mem_space_sel msel_checker u_chk (
  .clk(clk), .rst_n(rst_n), .srst_n(srst_n), .capture(capture), .boot_q(boot_q),
  .win_hit(win_hit), .wr_fall(wr_fall), .clr_evt(clr_evt), .bus16_i(bus16_i),
  .addr_i(addr_i), .fetch_i(fetch_i), .space_code_o(space_code_o)
);

// File: tb/sim_mem_space_sel.sv
module sim_mem_space_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0;
  logic        fetch = 1'b0, rd_n = 1'b1, wr_n = 1'b1, cyc = 1'b0;
  logic        bus16 = 1'b1, wide = 1'b0;
  logic        space;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  mem_space_sel u0 (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .fetch_i(fetch), .rd_n(rd_n),
    .wr_n(wr_n), .cyc_vld_i(cyc), .bus16_i(bus16), .wide_win_i(wide),
    .space_code_o(space)
  );

  // entry: {tag[3:0], wide, fetch, addr[15:0], expected}
  localparam int NV = 10;
  localparam logic [22:0] VEC [NV] = '{
    {4'd6, 1'b0, 1'b0, 16'h2000, 1'b1},   // R6 low edge
    {4'd6, 1'b0, 1'b0, 16'h207F, 1'b1},   // R6 high edge
    {4'd6, 1'b0, 1'b0, 16'h2080, 1'b0},   // R6 just past
    {4'd6, 1'b0, 1'b0, 16'h1FFF, 1'b0},   // R6 just below
    {4'd8, 1'b0, 1'b1, 16'h8000, 1'b1},   // R8 fetch high
    {4'd8, 1'b0, 1'b0, 16'h8000, 1'b0},   // R8 fetch low
    {4'd7, 1'b1, 1'b0, 16'h3FFF, 1'b1},   // R7 wide top
    {4'd7, 1'b1, 1'b0, 16'h2080, 1'b1},   // R7 inside wide only
    {4'd7, 1'b1, 1'b0, 16'h4000, 1'b0},   // R7 past wide
    {4'd7, 1'b1, 1'b1, 16'h4000, 1'b1}    // R7 fetch high outside
  };

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: space_code_o=%b expected %b", req, act, exp);
    end
  endtask

  // kind: 0 read, 1 write, 2 internal (no strobes)
  task automatic bus_cycle(logic [15:0] a, logic f, int kind);
    @(negedge clk);
    cyc = 1'b1; addr = a; fetch = f;
    if (kind == 0) rd_n = 1'b0;
    if (kind == 1) wr_n = 1'b0;
    repeat (6) @(negedge clk);
    rd_n = 1'b1; wr_n = 1'b1;
    repeat (4) @(negedge clk);
    cyc = 1'b0; fetch = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check("R1 during reset", space, 1'b1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after reset", space, 1'b1);

    bus_cycle(16'h8000, 1'b0, 0);
    check("R2 boot forces code", space, 1'b1);

    bus16 = 1'b1;
    bus_cycle(16'h8001, 1'b0, 1);
    bus_cycle(16'h8000, 1'b0, 0);
    check("R4 odd write keeps latch", space, 1'b1);

    bus_cycle(16'h8002, 1'b0, 1);
    bus_cycle(16'h8000, 1'b0, 0);
    check("R3 even write clears latch", space, 1'b0);

    // R10: idle with fetch high, output must hold
    fetch = 1'b1;
    repeat (5) @(negedge clk);
    check("R10 hold between cycles", space, 1'b0);
    fetch = 1'b0;

    for (int i = 0; i < NV; i++) begin
      wide = VEC[i][18];
      bus_cycle(VEC[i][16:1], VEC[i][17], 0);
      if (space !== VEC[i][0]) begin
        checks++; errors++;
        $display("FAIL R%0d vec %0d: space_code_o=%b expected %b",
                 VEC[i][22:19], i, space, VEC[i][0]);
      end else checks++;
    end
    wide = 1'b0;

    // R9: last vector left 1; internal access at data address must not change it
    bus_cycle(16'h8000, 1'b0, 2);
    check("R9 internal access ignored", space, 1'b1);

    // R11: reset sets latch again
    do_reset();
    bus_cycle(16'h8000, 1'b0, 0);
    check("R11 reset re-arms latch", space, 1'b1);

    // R9: internal access while latch set must not clear it
    bus_cycle(16'h8002, 1'b0, 2);
    bus_cycle(16'h8000, 1'b0, 0);
    check("R9 internal access keeps latch", space, 1'b1);

    // R5: 8-bit mode odd write clears
    bus16 = 1'b0;
    bus_cycle(16'h8001, 1'b0, 1);
    bus_cycle(16'h8000, 1'b0, 0);
    check("R5 8-bit odd write clears", space, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule